// File: doc/BRIEF.md
# Superscalar In-Order Dispatch Allocator

This block sits between an eight-deep instruction buffer and the reservation stations of six execution units. Each cycle it looks at the oldest four decoded instructions in the buffer. For each one it checks whether every resource that instruction needs is free. An instruction needs a reservation-station slot in its own unit, a completion-buffer slot, a rename slot of its destination class (when it writes a register) and its share of the register read ports. It then dispatches the longest in-order run of instructions that all pass. The first instruction that fails ends the group. No younger instruction may pass it in that cycle.

For each dispatched instruction the block hands out an allocation strobe, a completion-buffer tag and a rename tag. The tags come from circular pointers: one for the 16-entry completion buffer and one for each rename pool (integer 8, floating-point 8, condition 16). Each pointer advances by the number of slots taken from it. When dispatch stops short, the block reports one stall-reason code, taken from the oldest blocked instruction. All results are registered. They appear on the outputs one clock after the inputs are sampled.

The free-entry counts arrive from the resource owners, which account for the allocations themselves. Decoding, operand values and issue selection lie outside this block.

Top module: `dsp_alloc`

## Requirements
- R1: Slot 0 is the oldest instruction and slot 3 the youngest. The dispatched set is always a prefix of the slots: alloc_vld has its low disp_cnt bits set and no others. The outputs reflect the inputs sampled at the previous rising clock edge. An invalid slot ends the group without a stall.
- R2: At most one instruction per cycle goes to any one execution unit; units are numbered 0 to 5. A younger instruction aimed at a unit already taken in the group stalls with code 3. rs_alloc has one bit per unit, and bit u is set when unit u received an instruction.
- R3: An instruction dispatches only if its unit's free reservation count is non-zero. The count for unit u is rs_free[3u+2:3u]. Otherwise the code is 4.
- R4: The instruction in slot i needs cb_free of at least i+1. Otherwise the code is 5.
- R5: The destination class is encoded 0 none, 1 integer, 2 floating-point, 3 condition. An instruction of class c (not 0) needs the free count of pool c to exceed the number of older slots in the group of the same class. Otherwise the code is 6. The free count of pool c is ren_free[5c-1:5c-5]. Class 0 uses no rename entry.
- R6: The read ports needed by an instruction and all older ones in the group must together not exceed rdp_avail. Otherwise the code is 7.
- R7: A serializing instruction dispatches only from slot 0 while the completion buffer is empty (cb_free = 16). Once it has dispatched, no younger instruction follows in that cycle. Every violation reports code 1.
- R8: An instruction flagged as waiting on a special register stalls with code 2 while spr_pend is high. This applies only when the instruction targets the branch unit (unit 5). The flag has no effect on other units.
- R9: When an instruction fails several checks, its code is the lowest number that applies, in the order 1 to 7. The reported code is that of the oldest blocked instruction. The code is 0 when every valid slot dispatched.
- R10: Completion tags are consecutive modulo 16 from a circular pointer, in slot order. The pointer advances by disp_cnt each cycle.
- R11: Each dispatched instruction with a destination receives a tag from its class's pool pointer. Tags within a class are consecutive in slot order. Each pointer wraps at its pool depth and advances by the number of that class dispatched.
- R12: Synchronous reset clears disp_cnt, alloc_vld, rs_alloc and the stall code, and returns every tag pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_vld | input | 4 | Valid bit per slot, slot 0 oldest |
| slot_unit | input | 12 | Target unit per slot, 3 bits each |
| slot_dcls | input | 8 | Destination class per slot, 2 bits each |
| slot_serial | input | 4 | Serializing instruction flag per slot |
| slot_sprwait | input | 4 | Waits-on-special-register flag per slot |
| slot_rdp | input | 8 | Read ports needed per slot, 2 bits each |
| spr_pend | input | 1 | A special-register move is still outstanding |
| rs_free | input | 18 | Free reservation entries per unit, 3 bits each |
| cb_free | input | 5 | Free completion-buffer entries |
| ren_free | input | 15 | Free rename entries per class (int, fp, cr), 5 bits each |
| rdp_avail | input | 4 | Register read ports available this cycle |
| disp_cnt | output | 3 | Number of instructions dispatched |
| alloc_vld | output | 4 | Per-slot dispatch strobe |
| rs_alloc | output | 6 | Per-unit reservation allocation strobe |
| cb_tag | output | 16 | Completion tag per slot, 4 bits each |
| ren_tag | output | 16 | Rename tag per slot, 4 bits each |
| stall | output | 3 | Stall-reason code of the oldest blocked instruction |

## Verification
The embedded properties watch the following every cycle:
- the dispatched set stays a prefix;
- the unit strobes match the dispatch count, so no unit is used twice;
- no unit receives an instruction when it reported zero reservation room;
- the count never exceeds the completion space seen a cycle earlier;
- a dispatched serializer travels alone;
- a stall always leaves room in the group;
- tag pointers stay inside their rings.

Only the bench's scenarios can show the rest. These include the exact stall code chosen when checks overlap, the cumulative rename and read-port arithmetic across slots, and the branch-only effect of the special-register wait. They also include tag values through wrap-around and after reset, which the bench compares against its own reference model fed by directed and random traffic.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  typedef enum logic [1:0] {
    DC_NONE = 2'd0,
    DC_INT  = 2'd1,
    DC_FP   = 2'd2,
    DC_CR   = 2'd3
  } dclass_e;

  typedef enum logic [2:0] {
    ST_NONE      = 3'd0,
    ST_SERIAL    = 3'd1,
    ST_SPR       = 3'd2,
    ST_UNIT_BUSY = 3'd3,
    ST_RS_FULL   = 3'd4,
    ST_CB_FULL   = 3'd5,
    ST_REN_FULL  = 3'd6,
    ST_PORTS     = 3'd7
  } stall_e;

endpackage

// File: rtl/dsp_slot_chk.sv
// Resource check for one dispatch slot, given what the older slots of the
// group consume. Produces a pass flag and the highest-priority stall reason.
module dsp_slot_chk
  import dsp_pkg::*;
#(
  parameter int DISP_IDX  = 0,
  parameter int NUM_UNITS = 6,
  parameter int UNIT_W    = 3,
  parameter int BR_UNIT   = 5,
  parameter int RS_CNT_W  = 3,
  parameter int CB_DEPTH  = 16,
  parameter int CB_CNT_W  = 5,
  parameter int REN_CNT_W = 5,
  parameter int CNT_W     = 3,
  parameter int SUM_W     = 4,
  parameter int RDP_W     = 2,
  parameter int RDP_AV_W  = 4
) (
  input  logic                          vld,
  input  logic [UNIT_W-1:0]             unit,
  input  dclass_e                       dcls,
  input  logic                          serial,
  input  logic                          sprwait,
  input  logic                          spr_pend,
  input  logic [NUM_UNITS-1:0]          older_units,
  input  logic                          older_ser,
  input  logic [CNT_W-1:0]              older_cls,
  input  logic [SUM_W-1:0]              older_rdp,
  input  logic [RDP_W-1:0]              own_rdp,
  input  logic [NUM_UNITS*RS_CNT_W-1:0] rs_free,
  input  logic [CB_CNT_W-1:0]           cb_free,
  input  logic [3*REN_CNT_W-1:0]        ren_free,
  input  logic [RDP_AV_W-1:0]           rdp_avail,
  output logic                          ok,
  output stall_e                        reason
);

  logic [RS_CNT_W-1:0]  rs_sel;
  logic [REN_CNT_W-1:0] ren_sel;
  logic                 busy;
  logic                 ser_block;

  // Pick the reservation count and busy bit of this slot's unit.
  always_comb begin
    rs_sel = '0;
    busy   = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (unit == UNIT_W'(u)) begin
        rs_sel = rs_free[u*RS_CNT_W +: RS_CNT_W];
        busy   = older_units[u];
      end
    end
  end

  // Pick the free count of this slot's rename pool.
  always_comb begin
    case (dcls)
      DC_INT:  ren_sel = ren_free[0*REN_CNT_W +: REN_CNT_W];
      DC_FP:   ren_sel = ren_free[1*REN_CNT_W +: REN_CNT_W];
      DC_CR:   ren_sel = ren_free[2*REN_CNT_W +: REN_CNT_W];
      default: ren_sel = '0;
    endcase
  end

  assign ser_block = older_ser ||
                     (serial && ((DISP_IDX != 0) || (int'(cb_free) != CB_DEPTH)));

  // Fixed priority: the first failing check names the reason.
  always_comb begin
    if (!vld)
      reason = ST_NONE;
    else if (ser_block)
      reason = ST_SERIAL;
    else if (sprwait && spr_pend && (int'(unit) == BR_UNIT))
      reason = ST_SPR;
    else if (busy)
      reason = ST_UNIT_BUSY;
    else if (rs_sel == '0)
      reason = ST_RS_FULL;
    else if (int'(cb_free) <= DISP_IDX)
      reason = ST_CB_FULL;
    else if ((dcls != DC_NONE) && (int'(ren_sel) <= int'(older_cls)))
      reason = ST_REN_FULL;
    else if ((int'(older_rdp) + int'(own_rdp)) > int'(rdp_avail))
      reason = ST_PORTS;
    else
      reason = ST_NONE;
  end

  assign ok = vld && (reason == ST_NONE);

endmodule

// File: rtl/dsp_tag_ring.sv
// Circular tag pointer for one resource pool. Hands out ptr+offset tags per
// slot and advances by the number of entries taken.
module dsp_tag_ring #(
  parameter int DEPTH = 16,
  parameter int NSLOT = 4,
  parameter int OFF_W = 3,
  parameter int OUT_W = 4,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [OFF_W-1:0]       adv,
  input  logic [NSLOT*OFF_W-1:0] offs,
  output logic [NSLOT*OUT_W-1:0] tags
);

  logic [TW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else
      ptr <= TW'((int'(ptr) + int'(adv)) % DEPTH);
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_tag
    assign tags[s*OUT_W +: OUT_W] =
      OUT_W'((int'(ptr) + int'(offs[s*OFF_W +: OFF_W])) % DEPTH);
  end

  // R10 / R11: the pointer never leaves its ring, also for odd depths.
  p_ptr_in_ring_r11: assert property (@(posedge clk) disable iff (rst)
    int'(ptr) < DEPTH);

endmodule

// File: rtl/dsp_alloc.sv
// In-order dispatch allocator: checks four oldest buffered instructions against
// unit, completion, rename and read-port resources, dispatches the passing
// prefix, hands out tags and reports the oldest stall reason.
module dsp_alloc
  import dsp_pkg::*;
#(
  parameter int DISP_W    = 4,
  parameter int NUM_UNITS = 6,
  parameter int BR_UNIT   = 5,
  parameter int RS_CNT_W  = 3,
  parameter int CB_DEPTH  = 16,
  parameter int INT_REN   = 8,
  parameter int FP_REN    = 8,
  parameter int CR_REN    = 16,
  parameter int RDP_W     = 2,
  parameter int RDP_AV_W  = 4,
  localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int CNT_W    = $clog2(DISP_W + 1),
  localparam int CB_TW    = $clog2(CB_DEPTH),
  localparam int CB_CNT_W = $clog2(CB_DEPTH + 1),
  localparam int REN_MAX  = (INT_REN > FP_REN) ? ((INT_REN > CR_REN) ? INT_REN : CR_REN)
                                               : ((FP_REN > CR_REN) ? FP_REN : CR_REN),
  localparam int REN_TW    = $clog2(REN_MAX),
  localparam int REN_CNT_W = $clog2(REN_MAX + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [DISP_W-1:0]             slot_vld,
  input  logic [DISP_W*UNIT_W-1:0]      slot_unit,
  input  logic [DISP_W*2-1:0]           slot_dcls,
  input  logic [DISP_W-1:0]             slot_serial,
  input  logic [DISP_W-1:0]             slot_sprwait,
  input  logic [DISP_W*RDP_W-1:0]       slot_rdp,
  input  logic                          spr_pend,
  input  logic [NUM_UNITS*RS_CNT_W-1:0] rs_free,
  input  logic [CB_CNT_W-1:0]           cb_free,
  input  logic [3*REN_CNT_W-1:0]        ren_free,
  input  logic [RDP_AV_W-1:0]           rdp_avail,
  output logic [CNT_W-1:0]              disp_cnt,
  output logic [DISP_W-1:0]             alloc_vld,
  output logic [NUM_UNITS-1:0]          rs_alloc,
  output logic [DISP_W*CB_TW-1:0]       cb_tag,
  output logic [DISP_W*REN_TW-1:0]      ren_tag,
  output logic [2:0]                    stall
);

  localparam int SUM_W = $clog2(DISP_W * ((1 << RDP_W) - 1) + 1);

  // ---------------- slot unpacking ----------------
  logic [UNIT_W-1:0] unit_a [DISP_W];
  dclass_e           cls_a  [DISP_W];
  logic [RDP_W-1:0]  rdp_a  [DISP_W];

  always_comb begin
    for (int i = 0; i < DISP_W; i++) begin
      unit_a[i] = slot_unit[i*UNIT_W +: UNIT_W];
      cls_a[i]  = dclass_e'(slot_dcls[i*2 +: 2]);
      rdp_a[i]  = slot_rdp[i*RDP_W +: RDP_W];
    end
  end

  // ---------------- consumption by older slots ----------------
  logic [NUM_UNITS-1:0] older_units [DISP_W];
  logic [CNT_W-1:0]     older_cls   [DISP_W];
  logic [SUM_W-1:0]     older_rdp   [DISP_W];
  logic [DISP_W-1:0]    older_ser;

  always_comb begin
    for (int i = 0; i < DISP_W; i++) begin
      older_units[i] = '0;
      older_cls[i]   = '0;
      older_rdp[i]   = '0;
      older_ser[i]   = 1'b0;
      for (int j = 0; j < i; j++) begin
        for (int u = 0; u < NUM_UNITS; u++) begin
          if (unit_a[j] == UNIT_W'(u))
            older_units[i][u] = 1'b1;
        end
        if (cls_a[j] == cls_a[i])
          older_cls[i] = older_cls[i] + CNT_W'(1);
        older_rdp[i] = older_rdp[i] + SUM_W'(rdp_a[j]);
        if (slot_serial[j])
          older_ser[i] = 1'b1;
      end
    end
  end

  // ---------------- per-slot checks ----------------
  logic [DISP_W-1:0] slot_ok;
  stall_e            slot_why [DISP_W];

  for (genvar i = 0; i < DISP_W; i++) begin : g_chk
    dsp_slot_chk #(
      .DISP_IDX (i),
      .NUM_UNITS(NUM_UNITS),
      .UNIT_W   (UNIT_W),
      .BR_UNIT  (BR_UNIT),
      .RS_CNT_W (RS_CNT_W),
      .CB_DEPTH (CB_DEPTH),
      .CB_CNT_W (CB_CNT_W),
      .REN_CNT_W(REN_CNT_W),
      .CNT_W    (CNT_W),
      .SUM_W    (SUM_W),
      .RDP_W    (RDP_W),
      .RDP_AV_W (RDP_AV_W)
    ) u_chk (
      .vld        (slot_vld[i]),
      .unit       (unit_a[i]),
      .dcls       (cls_a[i]),
      .serial     (slot_serial[i]),
      .sprwait    (slot_sprwait[i]),
      .spr_pend   (spr_pend),
      .older_units(older_units[i]),
      .older_ser  (older_ser[i]),
      .older_cls  (older_cls[i]),
      .older_rdp  (older_rdp[i]),
      .own_rdp    (rdp_a[i]),
      .rs_free    (rs_free),
      .cb_free    (cb_free),
      .ren_free   (ren_free),
      .rdp_avail  (rdp_avail),
      .ok         (slot_ok[i]),
      .reason     (slot_why[i])
    );
  end

  // ---------------- in-order cut-off ----------------
  logic [DISP_W-1:0]    disp_c;
  logic [CNT_W-1:0]     disp_n;
  logic [NUM_UNITS-1:0] rs_alloc_c;
  stall_e               stall_c;
  logic [CNT_W-1:0]     ren_adv [3];

  always_comb begin
    logic go;
    go         = 1'b1;
    disp_c     = '0;
    disp_n     = '0;
    rs_alloc_c = '0;
    stall_c    = ST_NONE;
    for (int c = 0; c < 3; c++) ren_adv[c] = '0;
    for (int i = 0; i < DISP_W; i++) begin
      if (go && slot_vld[i]) begin
        if (slot_ok[i]) begin
          disp_c[i] = 1'b1;
          disp_n    = disp_n + CNT_W'(1);
          for (int u = 0; u < NUM_UNITS; u++) begin
            if (unit_a[i] == UNIT_W'(u))
              rs_alloc_c[u] = 1'b1;
          end
          for (int c = 0; c < 3; c++) begin
            if (cls_a[i] == dclass_e'(c + 1))
              ren_adv[c] = ren_adv[c] + CNT_W'(1);
          end
        end else begin
          stall_c = slot_why[i];
          go      = 1'b0;
        end
      end else begin
        go = 1'b0;
      end
    end
  end

  // ---------------- tag rings ----------------
  logic [DISP_W*CNT_W-1:0]  cb_offs;
  logic [DISP_W*CNT_W-1:0]  ren_offs;
  logic [DISP_W*CB_TW-1:0]  cb_tag_c;
  logic [DISP_W*REN_TW-1:0] rtag_c [3];
  logic [DISP_W*REN_TW-1:0] ren_tag_c;

  for (genvar i = 0; i < DISP_W; i++) begin : g_offs
    assign cb_offs[i*CNT_W +: CNT_W]  = CNT_W'(i);
    assign ren_offs[i*CNT_W +: CNT_W] = older_cls[i];
  end

  dsp_tag_ring #(
    .DEPTH(CB_DEPTH),
    .NSLOT(DISP_W),
    .OFF_W(CNT_W),
    .OUT_W(CB_TW)
  ) u_cb_ring (
    .clk (clk),
    .rst (rst),
    .adv (disp_n),
    .offs(cb_offs),
    .tags(cb_tag_c)
  );

  for (genvar c = 0; c < 3; c++) begin : g_ren
    localparam int DEP = (c == 0) ? INT_REN : ((c == 1) ? FP_REN : CR_REN);
    dsp_tag_ring #(
      .DEPTH(DEP),
      .NSLOT(DISP_W),
      .OFF_W(CNT_W),
      .OUT_W(REN_TW)
    ) u_ring (
      .clk (clk),
      .rst (rst),
      .adv (ren_adv[c]),
      .offs(ren_offs),
      .tags(rtag_c[c])
    );
  end

  always_comb begin
    for (int i = 0; i < DISP_W; i++) begin
      case (cls_a[i])
        DC_INT:  ren_tag_c[i*REN_TW +: REN_TW] = rtag_c[0][i*REN_TW +: REN_TW];
        DC_FP:   ren_tag_c[i*REN_TW +: REN_TW] = rtag_c[1][i*REN_TW +: REN_TW];
        DC_CR:   ren_tag_c[i*REN_TW +: REN_TW] = rtag_c[2][i*REN_TW +: REN_TW];
        default: ren_tag_c[i*REN_TW +: REN_TW] = '0;
      endcase
    end
  end

  // ---------------- output registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      disp_cnt  <= '0;
      alloc_vld <= '0;
      rs_alloc  <= '0;
      cb_tag    <= '0;
      ren_tag   <= '0;
      stall     <= ST_NONE;
    end else begin
      disp_cnt  <= disp_n;
      alloc_vld <= disp_c;
      rs_alloc  <= rs_alloc_c;
      cb_tag    <= cb_tag_c;
      ren_tag   <= ren_tag_c;
      stall     <= stall_c;
    end
  end

  // ---------------- assertions ----------------
  // R1: the dispatched set is a prefix of the slots.
  p_prefix_r1: assert property (@(posedge clk) disable iff (rst)
    alloc_vld == DISP_W'((1 << disp_cnt) - 1));

  // R2: each dispatched instruction used a distinct unit.
  p_one_per_unit_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(rs_alloc) == int'(disp_cnt));

  // R3: a unit only receives work when it reported room.
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_rs_chk
    p_rs_room_r3: assert property (@(posedge clk) disable iff (rst)
      rs_alloc[u] |-> ($past(rs_free[u*RS_CNT_W +: RS_CNT_W]) != '0));
  end

  // R4: never more dispatches than completion entries offered.
  p_cb_room_r4: assert property (@(posedge clk) disable iff (rst)
    int'(disp_cnt) <= int'($past(cb_free)));

  // R7: a dispatched serializer travels alone.
  p_serial_alone_r7: assert property (@(posedge clk) disable iff (rst)
    (alloc_vld[0] && $past(slot_serial[0])) |-> (disp_cnt == CNT_W'(1)));

  // R9: a reported stall means the group was cut short.
  p_stall_short_r9: assert property (@(posedge clk) disable iff (rst)
    (stall != 3'd0) |-> (int'(disp_cnt) < DISP_W));

endmodule

// File: tb/dsp_alloc_test.sv
`timescale 1ns/1ps
module dsp_alloc_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  s_vld = '0;
  logic [11:0] s_unit = '0;
  logic [7:0]  s_cls = '0;
  logic [3:0]  s_ser = '0;
  logic [3:0]  s_spr = '0;
  logic [7:0]  s_rdp = '0;
  logic        spr_pend = 1'b0;
  logic [17:0] rs_free = '0;
  logic [4:0]  cb_free = '0;
  logic [14:0] ren_free = '0;
  logic [3:0]  rdp_av = '0;

  logic [2:0]  disp_cnt;
  logic [3:0]  alloc_vld;
  logic [5:0]  rs_alloc;
  logic [15:0] cb_tag;
  logic [15:0] ren_tag;
  logic [2:0]  stall;

  always #5 clk = ~clk;

  dsp_alloc uut (
    .clk(clk), .rst(rst),
    .slot_vld(s_vld), .slot_unit(s_unit), .slot_dcls(s_cls),
    .slot_serial(s_ser), .slot_sprwait(s_spr), .slot_rdp(s_rdp),
    .spr_pend(spr_pend), .rs_free(rs_free), .cb_free(cb_free),
    .ren_free(ren_free), .rdp_avail(rdp_av),
    .disp_cnt(disp_cnt), .alloc_vld(alloc_vld), .rs_alloc(rs_alloc),
    .cb_tag(cb_tag), .ren_tag(ren_tag), .stall(stall)
  );

  typedef struct {
    int         cnt;
    logic [3:0] vld;
    logic [5:0] rsa;
    int         stl;
    int         cbt [4];
    int         rnt [4];
    int         rcl [4];
    string      req;
  } exp_t;

  exp_t  sb[$];
  int    errs = 0;
  int    checks = 0;
  int    cbp = 0;
  int    rp [4] = '{0, 0, 0, 0};
  int    rdep [4] = '{1, 8, 8, 16};

  task automatic chk(bit good, string req, string what, int act, int exp);
    checks++;
    if (!good) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  function automatic exp_t model(string req);
    exp_t e;
    int   used [6];
    int   cc [4];
    int   rsum;
    bit   ser;
    int   u, c, rd, r;
    e.cnt = 0; e.vld = '0; e.rsa = '0; e.stl = 0; e.req = req;
    for (int k = 0; k < 4; k++) begin e.cbt[k] = 0; e.rnt[k] = 0; e.rcl[k] = 0; cc[k] = 0; end
    for (int k = 0; k < 6; k++) used[k] = 0;
    rsum = 0; ser = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (!s_vld[i]) break;
      u  = int'(s_unit[i*3 +: 3]);
      c  = int'(s_cls[i*2 +: 2]);
      rd = int'(s_rdp[i*2 +: 2]);
      r  = 0;
      if ((s_ser[i] && (i != 0 || cb_free != 5'd16)) || ser) r = 1;
      else if (s_spr[i] && spr_pend && u == 5) r = 2;
      else if (used[u] != 0) r = 3;
      else if (rs_free[u*3 +: 3] == 3'd0) r = 4;
      else if (int'(cb_free) <= i) r = 5;
      else if (c != 0 && int'(ren_free[(c-1)*5 +: 5]) <= cc[c]) r = 6;
      else if (rsum + rd > int'(rdp_av)) r = 7;
      if (r != 0) begin e.stl = r; break; end
      e.vld[i] = 1'b1; e.cnt++; e.rsa[u] = 1'b1; used[u] = 1;
      e.cbt[i] = (cbp + i) % 16;
      e.rcl[i] = c;
      if (c != 0) begin e.rnt[i] = (rp[c] + cc[c]) % rdep[c]; cc[c]++; end
      rsum += rd;
      if (s_ser[i]) ser = 1'b1;
    end
    cbp = (cbp + e.cnt) % 16;
    for (int k = 1; k < 4; k++) rp[k] = (rp[k] + cc[k]) % rdep[k];
    return e;
  endfunction

  task automatic send(string req);
    sb.push_back(model(req));
  endtask

  task automatic clear_slots();
    s_vld = '0; s_unit = '0; s_cls = '0; s_ser = '0; s_spr = '0; s_rdp = '0;
  endtask

  task automatic plenty();
    spr_pend = 1'b0;
    rs_free  = {6{3'd2}};
    cb_free  = 5'd16;
    ren_free = {5'd16, 5'd8, 5'd8};
    rdp_av   = 4'd12;
  endtask

  task automatic slot(int i, int u, int c, bit ser, bit spr, int rd);
    s_vld[i]          = 1'b1;
    s_unit[i*3 +: 3]  = 3'(u);
    s_cls[i*2 +: 2]   = 2'(c);
    s_ser[i]          = ser;
    s_spr[i]          = spr;
    s_rdp[i*2 +: 2]   = 2'(rd);
  endtask

  task automatic step_begin();
    @(negedge clk);
    clear_slots();
    plenty();
  endtask

  // Monitor: compares the registered outputs after each edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() != 0) begin
        e = sb.pop_front();
        chk(int'(disp_cnt) == e.cnt, e.req, "disp_cnt", int'(disp_cnt), e.cnt);
        chk(alloc_vld == e.vld, e.req, "alloc_vld", int'(alloc_vld), int'(e.vld));
        chk(rs_alloc == e.rsa, e.req, "rs_alloc", int'(rs_alloc), int'(e.rsa));
        chk(int'(stall) == e.stl, e.req, "stall", int'(stall), e.stl);
        for (int i = 0; i < 4; i++) begin
          if (e.vld[i]) begin
            chk(int'(cb_tag[i*4 +: 4]) == e.cbt[i], e.req, "cb_tag",
                int'(cb_tag[i*4 +: 4]), e.cbt[i]);
            if (e.rcl[i] != 0)
              chk(int'(ren_tag[i*4 +: 4]) == e.rnt[i], e.req, "ren_tag",
                  int'(ren_tag[i*4 +: 4]), e.rnt[i]);
          end
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    // R12: reset state.
    plenty();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(disp_cnt == 3'd0, "R12", "disp_cnt", int'(disp_cnt), 0);
    chk(alloc_vld == 4'd0 && rs_alloc == 6'd0, "R12", "strobes", int'({alloc_vld, rs_alloc}), 0);
    chk(stall == 3'd0, "R12", "stall", int'(stall), 0);
    rst = 1'b0;

    // R1: four distinct units, all resources plentiful.
    step_begin();
    slot(0, 0, 1, 0, 0, 2); slot(1, 1, 1, 0, 0, 2); slot(2, 4, 2, 0, 0, 1); slot(3, 5, 0, 0, 0, 1);
    send("R1");
    // R1: invalid slot ends group without stall.
    step_begin();
    slot(0, 2, 3, 0, 0, 1); slot(1, 3, 3, 0, 0, 1); slot(3, 4, 1, 0, 0, 1);
    send("R1");
    // R2: same unit twice.
    step_begin();
    slot(0, 0, 1, 0, 0, 1); slot(1, 4, 0, 0, 0, 1); slot(2, 0, 1, 0, 0, 1); slot(3, 1, 1, 0, 0, 1);
    send("R2");
    // R3: reservation station of unit 3 full.
    step_begin();
    rs_free[3*3 +: 3] = 3'd0;
    slot(0, 1, 1, 0, 0, 1); slot(1, 3, 1, 0, 0, 1); slot(2, 2, 1, 0, 0, 1);
    send("R3");
    // R4: completion buffer has two entries.
    step_begin();
    cb_free = 5'd2;
    slot(0, 0, 0, 0, 0, 0); slot(1, 1, 0, 0, 0, 0); slot(2, 2, 0, 0, 0, 0); slot(3, 3, 0, 0, 0, 0);
    send("R4");
    // R5: one integer rename entry left; class none passes.
    step_begin();
    ren_free[0 +: 5] = 5'd1;
    slot(0, 0, 1, 0, 0, 1); slot(1, 5, 0, 0, 0, 1); slot(2, 1, 1, 0, 0, 1);
    send("R5");
    // R5: condition pool empty stalls slot 0.
    step_begin();
    ren_free[10 +: 5] = 5'd0;
    slot(0, 5, 3, 0, 0, 0);
    send("R5");
    // R6: read ports cumulative.
    step_begin();
    rdp_av = 4'd5;
    slot(0, 0, 1, 0, 0, 2); slot(1, 1, 1, 0, 0, 3); slot(2, 2, 1, 0, 0, 1);
    send("R6");
    // R7: serializer in slot 1.
    step_begin();
    slot(0, 0, 1, 0, 0, 1); slot(1, 1, 1, 1, 0, 1);
    send("R7");
    // R7: serializer in slot 0 with busy completion buffer.
    step_begin();
    cb_free = 5'd15;
    slot(0, 1, 1, 1, 0, 1); slot(1, 2, 1, 0, 0, 1);
    send("R7");
    // R7: serializer dispatches alone.
    step_begin();
    slot(0, 1, 1, 1, 0, 1); slot(1, 2, 1, 0, 0, 1);
    send("R7");
    // R8: branch waiting on special register.
    step_begin();
    spr_pend = 1'b1;
    slot(0, 0, 1, 0, 0, 1); slot(1, 5, 0, 0, 1, 1); slot(2, 2, 1, 0, 0, 1);
    send("R8");
    // R8: flag on a non-branch unit has no effect.
    step_begin();
    spr_pend = 1'b1;
    slot(0, 2, 1, 0, 1, 1); slot(1, 3, 1, 0, 1, 1);
    send("R8");
    // R9: unit busy outranks reservation full.
    step_begin();
    rs_free[4*3 +: 3] = 3'd1;
    slot(0, 4, 1, 0, 0, 1); slot(1, 4, 1, 0, 0, 1);
    send("R9");
    // R9: reservation full outranks ports and rename.
    step_begin();
    rs_free[2*3 +: 3] = 3'd0; rdp_av = 4'd0; ren_free[5 +: 5] = 5'd0;
    slot(0, 2, 2, 0, 0, 3);
    send("R9");
    // R10 / R11: wrap completion and rename rings.
    for (int n = 0; n < 6; n++) begin
      step_begin();
      slot(0, 0, 1, 0, 0, 1); slot(1, 1, 1, 0, 0, 1); slot(2, 4, 2, 0, 0, 1); slot(3, 5, 3, 0, 0, 1);
      send("R10");
    end
    step_begin();
    slot(0, 0, 2, 0, 0, 1); slot(1, 1, 2, 0, 0, 1); slot(2, 2, 3, 0, 0, 1);
    send("R11");

    // R12: reset returns pointers to zero.
    @(negedge clk);
    clear_slots();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cbp = 0;
    for (int k = 0; k < 4; k++) rp[k] = 0;
    step_begin();
    slot(0, 0, 1, 0, 0, 1); slot(1, 1, 3, 0, 0, 1);
    send("R12");

    // Random traffic against the reference model.
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      clear_slots();
      for (int i = 0; i < 4; i++) begin
        if (($urandom % 8) != 0)
          slot(i, int'($urandom % 6), int'($urandom % 4), ($urandom % 10) == 0,
               ($urandom % 5) == 0, int'($urandom % 4));
      end
      spr_pend = 1'($urandom % 2);
      for (int u = 0; u < 6; u++) rs_free[u*3 +: 3] = 3'($urandom % 4);
      cb_free  = 5'($urandom % 17);
      ren_free = {5'($urandom % 17), 5'($urandom % 9), 5'($urandom % 9)};
      rdp_av   = 4'($urandom % 13);
      send("R9");
    end

    @(negedge clk);
    clear_slots();
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R1", "scoreboard drained", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule